// File: doc/BRIEF.md
# Two-Stage Power Gating Sequencer

This controller takes one processor core into and out of a power-gated state. It runs on an always-on clock and drives the core's clock enable, its retention and clamp controls, its active-low asynchronous reset and ten header-switch group lines. Going to sleep, the core clock is stopped first, state is then held in retention cells with the outputs clamped, and finally every switch group is turned off. Waking up runs the same steps backwards. The wake-up is split into two stages to limit inrush current.

A wake-up mode number k from 1 to 10 picks how many switch groups conduct in the first stage. Groups 0..k-1 turn on first. After a programmable charge time the remaining groups join them. A larger k charges faster but draws more current. Each mode has its own charge time, held in a ten-entry table of cycle counts. The table is loaded with defaults at reset and can be rewritten through a small configuration port. After the core reset pulse and the retention release, a fixed number of restore cycles with the clock running lets the pipeline refill before the core is flagged ready.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the block reports a running core: clkEnable=1, retainOn=0, clampOn=0, coreRstN=1, coreReady=1 and all modeLines=0. A mode line at 0 means its switch group conducts; at 1 the group is off.
- R2: A sleepReq sampled while running starts the power-down. One cycle after the sampling edge, clkEnable and coreReady go low. One cycle later, retainOn and clampOn go high. One cycle after that, all ten modeLines are 1, and they stay 1 while the core is gated.
- R3: In the first wake-up stage with mode k, modeLines[i] is 0 for i<k and 1 for i>=k. k is taken from wakeMode on the edge that starts the wake-up, and later changes of wakeMode have no effect on that wake-up.
- R4: A wakeMode of 0 or of 11 to 15 is treated as mode 1.
- R5: The first-stage pattern lasts max(T[k],1) cycles, where T[k] is the table entry for mode k. The reset default is T[k] = 12-k.
- R6: The first stage is followed by exactly one cycle with all modeLines at 0 and coreRstN=1. Then comes exactly one cycle with coreRstN=0.
- R7: In the cycle after the reset pulse, retainOn and clampOn return to 0 while clkEnable is still 0. In the next cycle clkEnable returns to 1. coreReady rises after 4 cycles with the clock running.
- R8: A cycle with cfgWrEn=1 and cfgSel in 1..10 writes cfgCount into T[cfgSel], and wake-ups that start later use the new value. A write with cfgSel of 0 or above 10 changes no entry.
- R9: A wakeReq sampled during the power-down sequence is held. The block finishes the power-down, spends one cycle gated, and then starts the wake-up.
- R10: wakeReq is ignored while the core is running and during a wake-up. sleepReq is ignored everywhere except while running.
- R11: A wakeReq sampled while gated starts the wake-up. The first-stage pattern appears one cycle after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer |
| sleepReq | input | 1 | Request to power-gate the core |
| wakeReq | input | 1 | Request to wake the core |
| wakeMode | input | 4 | Wake-up mode number, 1..10 |
| cfgWrEn | input | 1 | Charge-time table write strobe |
| cfgSel | input | 4 | Mode whose charge time is written |
| cfgCount | input | 8 | Charge time in cycles |
| clkEnable | output | 1 | Core clock enable, 1 = running |
| retainOn | output | 1 | Retention hold, 1 = hold state |
| clampOn | output | 1 | Output clamp, 1 = clamped |
| coreRstN | output | 1 | Active-low asynchronous reset to the core |
| coreReady | output | 1 | Core running and usable |
| modeLines | output | 10 | Switch group controls, 0 = group on |

## Verification
Every output is a register fed by state that was itself updated on the same edge, so a request sampled on edge E shows its first effect after edge E+1. The power-down steps then follow at one cycle each. On a wake-up, the first-stage pattern holds for the charge count. It is followed by one second-stage cycle, one reset cycle, one release cycle and four restore cycles before ready. The bench drives and samples on the falling edge and compares the whole output vector after every rising edge against a phase sequence it builds from these counts. A late or early step therefore shows up as a mismatch in that exact cycle.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_CLKOFF,
    ST_RETAIN,
    ST_OFF,
    ST_CHARGE,
    ST_STAGE2,
    ST_RESET,
    ST_RELEASE,
    ST_RESTORE
  } seqState_t;

  typedef struct packed {
    logic clkRun;
    logic retain;
    logic stage1;
    logic stage2;
    logic rstHold;
    logic ready;
    logic loadCharge;
    logic loadRestore;
  } seqStrobe_t;

endpackage

// File: rtl/pgs_ctrl.sv
module pgs_ctrl
  import pgs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       chargeDone,
  input  logic       restoreDone,
  output seqStrobe_t strobe
);

  seqState_t state, nextState;
  logic wakePending;
  logic wakeGo;

  assign wakeGo = wakeReq || wakePending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_RUN;
      wakePending <= 1'b0;
    end else begin
      state <= nextState;
      if ((state == ST_CLKOFF || state == ST_RETAIN) && wakeReq)
        wakePending <= 1'b1;
      else if (state == ST_OFF && wakeGo)
        wakePending <= 1'b0;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_RUN: begin
        strobe.clkRun = 1'b1;
        strobe.stage1 = 1'b1;
        strobe.stage2 = 1'b1;
        strobe.ready  = 1'b1;
        if (sleepReq) nextState = ST_CLKOFF;
      end
      ST_CLKOFF: begin
        strobe.stage1 = 1'b1;
        strobe.stage2 = 1'b1;
        nextState     = ST_RETAIN;
      end
      ST_RETAIN: begin
        strobe.retain = 1'b1;
        strobe.stage1 = 1'b1;
        strobe.stage2 = 1'b1;
        nextState     = ST_OFF;
      end
      ST_OFF: begin
        strobe.retain = 1'b1;
        if (wakeGo) begin
          strobe.loadCharge = 1'b1;
          nextState         = ST_CHARGE;
        end
      end
      ST_CHARGE: begin
        strobe.retain = 1'b1;
        strobe.stage1 = 1'b1;
        if (chargeDone) nextState = ST_STAGE2;
      end
      ST_STAGE2: begin
        strobe.retain = 1'b1;
        strobe.stage1 = 1'b1;
        strobe.stage2 = 1'b1;
        nextState     = ST_RESET;
      end
      ST_RESET: begin
        strobe.retain  = 1'b1;
        strobe.stage1  = 1'b1;
        strobe.stage2  = 1'b1;
        strobe.rstHold = 1'b1;
        nextState      = ST_RELEASE;
      end
      ST_RELEASE: begin
        strobe.stage1      = 1'b1;
        strobe.stage2      = 1'b1;
        strobe.loadRestore = 1'b1;
        nextState          = ST_RESTORE;
      end
      ST_RESTORE: begin
        strobe.clkRun = 1'b1;
        strobe.stage1 = 1'b1;
        strobe.stage2 = 1'b1;
        if (restoreDone) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

endmodule

// File: rtl/pgs_datapath.sv
module pgs_datapath
  import pgs_pkg::*;
#(
  parameter int NUM_GROUPS     = 10,
  parameter int CNT_W          = 8,
  parameter int RESTORE_CYCLES = 4,
  parameter int CHARGE_BASE    = 2,
  parameter int CHARGE_STEP    = 1,
  parameter int MODE_W         = $clog2(NUM_GROUPS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [MODE_W-1:0]     wakeMode,
  input  logic                  cfgWrEn,
  input  logic [MODE_W-1:0]     cfgSel,
  input  logic [CNT_W-1:0]      cfgCount,
  output logic                  chargeDone,
  output logic                  restoreDone,
  output logic                  clkEnable,
  output logic                  retainOn,
  output logic                  clampOn,
  output logic                  coreRstN,
  output logic                  coreReady,
  output logic [NUM_GROUPS-1:0] modeLines
);

  localparam int RST_W = $clog2(RESTORE_CYCLES + 1);

  logic [CNT_W-1:0]  chargeTable [NUM_GROUPS];
  logic [CNT_W-1:0]  chargeCnt;
  logic [RST_W-1:0]  restoreCnt;
  logic [MODE_W-1:0] modeReg;
  logic [MODE_W-1:0] selMode;

  function automatic logic [MODE_W-1:0] clampMode(input logic [MODE_W-1:0] m);
    if (m == '0 || m > MODE_W'(NUM_GROUPS)) return MODE_W'(1);
    return m;
  endfunction

  assign selMode = clampMode(wakeMode);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gTable
    localparam int DEF = CHARGE_BASE + CHARGE_STEP * (NUM_GROUPS - 1 - g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chargeTable[g] <= CNT_W'(DEF);
      else if (cfgWrEn && cfgSel == MODE_W'(g + 1)) chargeTable[g] <= cfgCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg    <= MODE_W'(1);
      chargeCnt  <= '0;
      restoreCnt <= '0;
    end else begin
      if (strobe.loadCharge) begin
        modeReg   <= selMode;
        chargeCnt <= chargeTable[selMode - MODE_W'(1)];
      end else if (chargeCnt != '0) begin
        chargeCnt <= chargeCnt - CNT_W'(1);
      end
      if (strobe.loadRestore) restoreCnt <= RST_W'(RESTORE_CYCLES);
      else if (restoreCnt != '0) restoreCnt <= restoreCnt - RST_W'(1);
    end
  end

  assign chargeDone  = (chargeCnt <= CNT_W'(1));
  assign restoreDone = (restoreCnt <= RST_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkEnable <= 1'b1;
      retainOn  <= 1'b0;
      clampOn   <= 1'b0;
      coreRstN  <= 1'b1;
      coreReady <= 1'b1;
    end else begin
      clkEnable <= strobe.clkRun;
      retainOn  <= strobe.retain;
      clampOn   <= strobe.retain;
      coreRstN  <= !strobe.rstHold;
      coreReady <= strobe.ready;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gLine
    logic lineOn;
    assign lineOn = (MODE_W'(g) < modeReg) ? strobe.stage1 : strobe.stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) modeLines[g] <= 1'b0;
      else       modeLines[g] <= !lineOn;
    end
  end

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgs_pkg::*;
#(
  parameter int NUM_GROUPS     = 10,
  parameter int CNT_W          = 8,
  parameter int RESTORE_CYCLES = 4,
  parameter int CHARGE_BASE    = 2,
  parameter int CHARGE_STEP    = 1,
  localparam int MODE_W        = $clog2(NUM_GROUPS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sleepReq,
  input  logic                  wakeReq,
  input  logic [MODE_W-1:0]     wakeMode,
  input  logic                  cfgWrEn,
  input  logic [MODE_W-1:0]     cfgSel,
  input  logic [CNT_W-1:0]      cfgCount,
  output logic                  clkEnable,
  output logic                  retainOn,
  output logic                  clampOn,
  output logic                  coreRstN,
  output logic                  coreReady,
  output logic [NUM_GROUPS-1:0] modeLines
);

  seqStrobe_t strobe;
  logic chargeDone;
  logic restoreDone;

  pgs_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sleepReq    (sleepReq),
    .wakeReq     (wakeReq),
    .chargeDone  (chargeDone),
    .restoreDone (restoreDone),
    .strobe      (strobe)
  );

  pgs_datapath #(
    .NUM_GROUPS     (NUM_GROUPS),
    .CNT_W          (CNT_W),
    .RESTORE_CYCLES (RESTORE_CYCLES),
    .CHARGE_BASE    (CHARGE_BASE),
    .CHARGE_STEP    (CHARGE_STEP),
    .MODE_W         (MODE_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wakeMode    (wakeMode),
    .cfgWrEn     (cfgWrEn),
    .cfgSel      (cfgSel),
    .cfgCount    (cfgCount),
    .chargeDone  (chargeDone),
    .restoreDone (restoreDone),
    .clkEnable   (clkEnable),
    .retainOn    (retainOn),
    .clampOn     (clampOn),
    .coreRstN    (coreRstN),
    .coreReady   (coreReady),
    .modeLines   (modeLines)
  );

endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
  parameter int NUM_GROUPS = 10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clkEnable,
  input logic                  retainOn,
  input logic                  clampOn,
  input logic                  coreRstN,
  input logic                  coreReady,
  input logic [NUM_GROUPS-1:0] modeLines
);

  // R2: the clock is already stopped the cycle before retention engages
  a_r2_clock_stops_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(retainOn) |-> (!clkEnable && $past(!clkEnable)));

  // R2: switches are fully off only while state is held and clock is stopped
  a_r2_gate_needs_retention: assert property (@(posedge clk) disable iff (!rstN)
    (&modeLines) |-> (retainOn && clampOn && !clkEnable));

  // R3: conducting groups always form a run from group 0 upward
  a_r3_thermometer: assert property (@(posedge clk) disable iff (!rstN)
    !(&modeLines) |-> $onehot0((~modeLines) + NUM_GROUPS'(1)));

  // R6: reset falls only after a full cycle with every group on
  a_r6_stage2_before_reset: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreRstN) |-> (modeLines == '0 && $past(modeLines == '0)));

  // R6: reset pulse is one cycle long
  a_r6_reset_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !coreRstN |=> coreRstN);

  // R7: retention drops right after reset, with the clock still off
  a_r7_release_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $fell(retainOn) |-> ($past(!coreRstN) && !clkEnable && !clampOn));

  // R7: ready implies a fully powered, running, released core
  a_r7_ready_when_running: assert property (@(posedge clk) disable iff (!rstN)
    coreReady |-> (clkEnable && !retainOn && coreRstN && modeLines == '0));

endmodule

bind pwr_gate_seq pgs_checker #(.NUM_GROUPS(NUM_GROUPS)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .clkEnable (clkEnable),
  .retainOn  (retainOn),
  .clampOn   (clampOn),
  .coreRstN  (coreRstN),
  .coreReady (coreReady),
  .modeLines (modeLines)
);

// File: tb/test_pwr_gate_seq.sv
`timescale 1ns/1ps
module test_pwr_gate_seq;

  localparam int P_RUN = 0, P_CLKOFF = 1, P_RET = 2, P_OFF = 3, P_CHG = 4,
                 P_ST2 = 5, P_RST = 6, P_REL = 7, P_RES = 8;

  // vector: [12:9] wakeMode, [8] write table first, [7:0] count to write
  localparam logic [12:0] VEC [8] = '{
    {4'd1,  1'b0, 8'd0},
    {4'd10, 1'b0, 8'd0},
    {4'd5,  1'b0, 8'd0},
    {4'd0,  1'b0, 8'd0},
    {4'd15, 1'b0, 8'd0},
    {4'd3,  1'b1, 8'd20},
    {4'd7,  1'b1, 8'd1},
    {4'd8,  1'b1, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0, wakeReq = 1'b0, cfgWrEn = 1'b0;
  logic [3:0] wakeMode = 4'd1, cfgSel = 4'd0;
  logic [7:0] cfgCount = 8'd0;
  logic clkEnable, retainOn, clampOn, coreRstN, coreReady;
  logic [9:0] modeLines;
  logic [14:0] obs;

  int total = 0, bad = 0;
  int tbl [11];
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_gate_seq i_pwr_gate_seq (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .wakeMode(wakeMode), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgCount(cfgCount),
    .clkEnable(clkEnable), .retainOn(retainOn), .clampOn(clampOn),
    .coreRstN(coreRstN), .coreReady(coreReady), .modeLines(modeLines)
  );

  assign obs = {clkEnable, retainOn, clampOn, coreRstN, coreReady, modeLines};

  function automatic logic [14:0] expVec(int ph, int k);
    logic [9:0] therm;
    for (int i = 0; i < 10; i++) therm[i] = (i < k) ? 1'b0 : 1'b1;
    case (ph)
      P_RUN:    return {5'b10011, 10'h000};
      P_CLKOFF: return {5'b00010, 10'h000};
      P_RET:    return {5'b01110, 10'h000};
      P_OFF:    return {5'b01110, 10'h3FF};
      P_CHG:    return {5'b01110, therm};
      P_ST2:    return {5'b01110, 10'h000};
      P_RST:    return {5'b01100, 10'h000};
      P_REL:    return {5'b00010, 10'h000};
      default:  return {5'b10010, 10'h000};
    endcase
  endfunction

  function automatic int clampK(int m);
    return (m == 0 || m > 10) ? 1 : m;
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [14:0] exp);
    total++;
    if (obs !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, obs, exp, $time);
    end
  endtask

  task automatic cfgWrite(int sel, int cnt);
    cfgWrEn = 1'b1; cfgSel = sel[3:0]; cfgCount = cnt[7:0];
    step;
    cfgWrEn = 1'b0;
  endtask

  // sleep pulse; checks the three power-down steps and leaves the bench at j=4
  task automatic doSleep(bit wakeEarly);
    sleepReq = 1'b1;
    step;
    sleepReq = 1'b0;
    check("R2 run before clock stop", expVec(P_RUN, 0));
    if (wakeEarly) wakeReq = 1'b1;
    step;
    wakeReq = 1'b0;
    check("R2 clock stopped", expVec(P_CLKOFF, 0));
    step;
    check("R2 retention on", expVec(P_RET, 0));
    step;
  endtask

  // starts at the sample right after the edge that began the wake-up
  task automatic wakeTail(int k, int c, bit noisy, string chgTag);
    check("R11 gated at wake edge", expVec(P_OFF, k));
    for (int i = 0; i < c; i++) begin
      if (noisy && i == 0) begin
        sleepReq = 1'b1; wakeReq = 1'b1; wakeMode = 4'd9;
      end
      step;
      check(chgTag, expVec(P_CHG, k));
    end
    sleepReq = 1'b0; wakeReq = 1'b0;
    step;
    check("R6 second stage", expVec(P_ST2, k));
    step;
    check("R6 reset pulse", expVec(P_RST, k));
    step;
    check("R7 retention released", expVec(P_REL, k));
    for (int i = 0; i < 4; i++) begin
      step;
      check("R7 restore cycles", expVec(P_RES, k));
    end
    step;
    check("R7 core ready", expVec(P_RUN, k));
  endtask

  task automatic doWake(int mode, bit noisy, string chgTag);
    int k, c;
    k = clampK(mode);
    c = (tbl[k] == 0) ? 1 : tbl[k];
    wakeMode = mode[3:0];
    wakeReq = 1'b1;
    step;
    wakeReq = 1'b0;
    wakeTail(k, c, noisy, chgTag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 1; k <= 10; k++) tbl[k] = 12 - k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state", expVec(P_RUN, 0));
    step;
    check("R1 reset state held", expVec(P_RUN, 0));

    // table-driven sweep over modes and table rewrites
    for (int v = 0; v < 8; v++) begin
      int m;
      m = int'(VEC[v][12:9]);
      if (VEC[v][8]) begin
        cfgWrite(m, int'(VEC[v][7:0]));
        tbl[m] = int'(VEC[v][7:0]);
      end
      doSleep(1'b0);
      check("R2 gated", expVec(P_OFF, 0));
      step;
      check("R2 gated held", expVec(P_OFF, 0));
      if (VEC[v][8])               doWake(m, 1'b0, "R8 charge uses written count");
      else if (m == 0 || m > 10)   doWake(m, 1'b0, "R4 out-of-range mode clamps to 1");
      else                         doWake(m, 1'b0, "R5 charge pattern and length");
    end

    // R8: writes with select outside 1..10 change nothing
    cfgWrite(0, 50);
    cfgWrite(11, 50);
    doSleep(1'b0);
    check("R2 gated", expVec(P_OFF, 0));
    doWake(11, 1'b0, "R8 bad select left entry 1 intact");
    doSleep(1'b0);
    doWake(2, 1'b0, "R8 bad select left entry 2 intact");

    // R10: wake while running has no effect
    wakeReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step;
      check("R10 wake ignored while running", expVec(P_RUN, 0));
    end
    wakeReq = 1'b0;
    step;
    check("R10 still running", expVec(P_RUN, 0));

    // R9: wake during power-down is held and served after one gated cycle
    wakeMode = 4'd6;
    doSleep(1'b1);
    wakeTail(6, tbl[6], 1'b0, "R9 held wake runs first stage");

    // R10 and R3: sleep, wake and mode changes during wake-up are ignored
    doSleep(1'b0);
    doWake(4, 1'b1, "R3 latched mode ignores input change, R10 requests ignored");
    wakeMode = 4'd1;
    step;
    check("R10 running after noisy wake-up", expVec(P_RUN, 0));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule